// File: doc/BRIEF.md
# FEC Output Rate Smoother with Serial Option

This block sits after a block error decoder. The decoder delivers 188 data bytes per frame in a burst and then leaves 16 empty byte-times where the parity bytes were stripped. The smoother stores the bytes and sends them out again at an even rate of 188 bytes per 204 input byte-times, so the downstream stream has no 16-byte hole.

Each input byte-time is marked by a one-cycle `in_tick` strobe; a byte is stored only when `in_valid` is also high. A fractional accumulator picks the byte-times on which one stored byte leaves. The output is either an 8-bit parallel strobe or a bit-serial line, chosen by `serial_mode`. A start-of-frame marker and the decoder's per-frame undecodable flag travel with every byte. Byte-times must be at least 8 clock cycles apart so that a serial byte completes before the next slot.

Top module: `fec_rate_smoother`

## Requirements
- R1: An accumulator starts at 0 after reset and adds 188 on each `in_tick`. When the sum reaches 204 or more, that tick is an output slot and 204 is subtracted. Any 204 consecutive ticks therefore hold exactly 188 slots, and two slots are never more than 2 ticks apart.
- R2: With `serial_mode`=0, a slot that finds stored data raises `par_valid` for exactly one cycle, in the cycle after the slot tick's clock edge, with the oldest stored byte on `par_data`. Bytes leave in arrival order.
- R3: With `serial_mode`=1, a slot that finds stored data raises `ser_valid` for 8 consecutive cycles, starting in the cycle after the slot tick's edge. `ser_bit` carries the byte most significant bit first. A slot on which the serializer still has more than its last bit to send is lost.
- R4: The output form is taken from `serial_mode` at the slot edge that removes the byte. A change of mode takes effect with the next byte that leaves.
- R5: A byte written with `in_sof`=1 leaves with `frm_sof`=1: in parallel form together with its `par_valid`, and in serial form on its first bit only. `frm_sof` is 0 in every other cycle.
- R6: `in_bad` is taken on the start-of-frame byte and applies to every byte of that frame. `frm_bad` is 1 together with every `par_valid` or `ser_valid` cycle of such a byte, and 0 otherwise.
- R7: The buffer holds DEPTH bytes (default 256, at least one frame). A byte offered while the buffer is full is dropped and sets `overflow`, which stays 1 until reset.
- R8: A tick with `in_valid`=0 stores nothing. A slot that finds the buffer empty produces no output and is lost.
- R9: While `rst` is high and in the first cycle after it, `par_valid`, `ser_valid`, `frm_sof`, `frm_bad` and `overflow` are 0, and the buffer is emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| serial_mode | input | 1 | 1 selects bit-serial output, 0 selects byte-parallel |
| in_tick | input | 1 | One-cycle strobe marking an input byte-time |
| in_valid | input | 1 | A data byte is present on this byte-time |
| in_data | input | 8 | Decoded data byte |
| in_sof | input | 1 | First byte of a frame |
| in_bad | input | 1 | Frame is undecodable, taken with the first byte |
| par_valid | output | 1 | Parallel byte strobe |
| par_data | output | 8 | Parallel byte |
| ser_valid | output | 1 | Serial bit strobe |
| ser_bit | output | 1 | Serial data bit, most significant first |
| frm_sof | output | 1 | Start-of-frame marker for the byte or first bit |
| frm_bad | output | 1 | Undecodable flag for the byte or bit |
| overflow | output | 1 | Sticky buffer overflow |

## Verification
Bursty frames of 188 bytes followed by 16 idle byte-times, with garbage on the idle data lines, show that the gap is removed and the idle ticks store nothing. A continuous stream with no gaps keeps the buffer from running dry, so the exact 188-in-204 slot count and the 2-tick spacing can be measured. The same stream drives the buffer into overflow and shows that the overflow bit is sticky. Frames in serial form, a mode change in the middle of a frame, and undecodable frames separate the start-of-frame and flag timing of the two output forms. Empty ticks right after reset show that unused slots produce nothing.

// File: rtl/smooth_pkg.sv
package smooth_pkg;

    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned KEEP_DEF  = 188;
    localparam int unsigned SPAN_DEF  = 204;
    localparam int unsigned DEPTH_DEF = 256;

    // One stored byte together with its frame markers
    typedef struct packed {
        logic              bad;
        logic              sof;
        logic [BYTE_W-1:0] data;
    } cell_t;

    typedef enum logic {
        FORM_PAR = 1'b0,
        FORM_SER = 1'b1
    } form_e;

    // Pointer advance with wrap at an arbitrary depth
    function automatic int unsigned wrap_inc(input int unsigned ptr, input int unsigned depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/smooth_pacer.sv
module smooth_pacer
    import smooth_pkg::*;
#(
    parameter int unsigned KEEP = KEEP_DEF,
    parameter int unsigned SPAN = SPAN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic slot
);
    localparam int unsigned ACC_W = $clog2(SPAN) + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;
    logic             hit;

    always_comb begin
        sum  = acc_q + ACC_W'(KEEP);
        hit  = (sum >= ACC_W'(SPAN));
        slot = tick && hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= hit ? (sum - ACC_W'(SPAN)) : sum;
        end
    end

endmodule

// File: rtl/smooth_fifo.sv
module smooth_fifo
    import smooth_pkg::*;
#(
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  cell_t wcell,
    input  logic  pop,
    output cell_t rcell,
    output logic  empty,
    output logic  full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam bit          POW2 = (DEPTH == (1 << AW));

    cell_t          mem [DEPTH];
    logic [AW-1:0]  wptr_q, rptr_q;
    logic [AW-1:0]  wptr_nx, rptr_nx;
    logic [CW-1:0]  cnt_q;
    logic           do_wr, do_rd;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign rcell = mem[rptr_q];

    generate
        if (POW2) begin : g_pow2
            assign wptr_nx = wptr_q + 1'b1;
            assign rptr_nx = rptr_q + 1'b1;
        end else begin : g_wrap
            assign wptr_nx = AW'(wrap_inc(int'(wptr_q), DEPTH));
            assign rptr_nx = AW'(wrap_inc(int'(rptr_q), DEPTH));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wptr_q] <= wcell;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (do_wr) wptr_q <= wptr_nx;
            if (do_rd) rptr_q <= rptr_nx;
            case ({do_wr, do_rd})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/smooth_ser.sv
module smooth_ser
    import smooth_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  cell_t lcell,
    output logic  ready,
    output logic  active,
    output logic  sbit,
    output logic  first,
    output logic  bad
);
    localparam int unsigned CW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg_q;
    logic [CW-1:0]     pos_q;
    logic              act_q;
    logic              sof_q;
    logic              bad_q;
    logic              last;

    assign last   = (pos_q == CW'(BYTE_W - 1));
    assign ready  = !act_q || last;
    assign active = act_q;
    assign sbit   = shreg_q[BYTE_W-1];
    assign first  = act_q && (pos_q == '0) && sof_q;
    assign bad    = act_q && bad_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            pos_q   <= '0;
            act_q   <= 1'b0;
            sof_q   <= 1'b0;
            bad_q   <= 1'b0;
        end else if (load) begin
            shreg_q <= lcell.data;
            pos_q   <= '0;
            act_q   <= 1'b1;
            sof_q   <= lcell.sof;
            bad_q   <= lcell.bad;
        end else if (act_q) begin
            shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
            pos_q   <= pos_q + 1'b1;
            if (last) act_q <= 1'b0;
        end
    end

endmodule

// File: rtl/fec_rate_smoother.sv
module fec_rate_smoother
    import smooth_pkg::*;
#(
    parameter int unsigned KEEP  = KEEP_DEF,
    parameter int unsigned SPAN  = SPAN_DEF,
    parameter int unsigned DEPTH = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              serial_mode,
    input  logic              in_tick,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_bad,
    output logic              par_valid,
    output logic [BYTE_W-1:0] par_data,
    output logic              ser_valid,
    output logic              ser_bit,
    output logic              frm_sof,
    output logic              frm_bad,
    output logic              overflow
);
    logic   slot;
    logic   buf_empty, buf_full;
    logic   wr_req, rd_go;
    logic   bad_lat_q;
    logic   ovf_q;
    cell_t  wcell, rcell;
    form_e  form;
    logic   ser_ready, ser_act, ser_first, ser_bad;

    // Parallel output register
    logic              pv_q;
    logic [BYTE_W-1:0] pd_q;
    logic              psof_q, pbad_q;

    assign form   = serial_mode ? FORM_SER : FORM_PAR;
    assign wr_req = in_tick && in_valid;

    always_comb begin
        wcell.data = in_data;
        wcell.sof  = in_sof;
        wcell.bad  = in_sof ? in_bad : bad_lat_q;
    end

    // A byte leaves only when the serializer can take a new byte right
    // away, so the two output forms never overlap.
    assign rd_go = slot && !buf_empty && ser_ready;

    smooth_pacer #(
        .KEEP (KEEP),
        .SPAN (SPAN)
    ) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .tick (in_tick),
        .slot (slot)
    );

    smooth_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (wr_req),
        .wcell (wcell),
        .pop   (rd_go),
        .rcell (rcell),
        .empty (buf_empty),
        .full  (buf_full)
    );

    smooth_ser u_ser (
        .clk    (clk),
        .rst    (rst),
        .load   (rd_go && (form == FORM_SER)),
        .lcell  (rcell),
        .ready  (ser_ready),
        .active (ser_act),
        .sbit   (ser_bit),
        .first  (ser_first),
        .bad    (ser_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_lat_q <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (wr_req && in_sof) bad_lat_q <= in_bad;
            if (wr_req && buf_full) ovf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pv_q   <= 1'b0;
            pd_q   <= '0;
            psof_q <= 1'b0;
            pbad_q <= 1'b0;
        end else begin
            pv_q <= rd_go && (form == FORM_PAR);
            if (rd_go && (form == FORM_PAR)) begin
                pd_q   <= rcell.data;
                psof_q <= rcell.sof;
                pbad_q <= rcell.bad;
            end
        end
    end

    assign par_valid = pv_q;
    assign par_data  = pd_q;
    assign ser_valid = ser_act;
    assign frm_sof   = (pv_q && psof_q) || ser_first;
    assign frm_bad   = (pv_q && pbad_q) || ser_bad;
    assign overflow  = ovf_q;

endmodule

// File: rtl/fec_rate_smoother_chk.sv
module fec_rate_smoother_chk (
    input logic clk,
    input logic rst,
    input logic in_tick,
    input logic par_valid,
    input logic ser_valid,
    input logic frm_sof,
    input logic frm_bad,
    input logic overflow
);
    // R1: a parallel byte only follows a tick edge
    a_r1_par_after_tick: assert property (@(posedge clk) disable iff (rst)
        par_valid |-> $past(in_tick));

    // R3: a serial byte only starts after a tick edge
    a_r3_ser_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_valid) |-> $past(in_tick));

    // R4: the two output forms never run at once
    a_r4_one_form: assert property (@(posedge clk) disable iff (rst)
        !(par_valid && ser_valid));

    // R5: start marker only with output data
    a_r5_sof_with_data: assert property (@(posedge clk) disable iff (rst)
        frm_sof |-> (par_valid || ser_valid));

    // R6: undecodable flag only with output data
    a_r6_bad_with_data: assert property (@(posedge clk) disable iff (rst)
        frm_bad |-> (par_valid || ser_valid));

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

bind fec_rate_smoother fec_rate_smoother_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_tick   (in_tick),
    .par_valid (par_valid),
    .ser_valid (ser_valid),
    .frm_sof   (frm_sof),
    .frm_bad   (frm_bad),
    .overflow  (overflow)
);

// File: tb/fec_rate_smoother_tb.sv
module fec_rate_smoother_tb;

    localparam int KEEP  = 188;
    localparam int SPAN  = 204;
    localparam int DEPTH = 256;
    localparam int GAP   = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       serial_mode = 1'b0;
    logic       in_tick = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_bad = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       par_valid, ser_valid, ser_bit, frm_sof, frm_bad, overflow;
    logic [7:0] par_data;

    always #10 clk = ~clk;

    fec_rate_smoother u_dut (
        .clk(clk), .rst(rst), .serial_mode(serial_mode),
        .in_tick(in_tick), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_bad(in_bad),
        .par_valid(par_valid), .par_data(par_data),
        .ser_valid(ser_valid), .ser_bit(ser_bit),
        .frm_sof(frm_sof), .frm_bad(frm_bad), .overflow(overflow)
    );

    int checks = 0;
    int fails  = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [9:0] q[$];
    int         acc = 0;
    int         rem = 0;
    logic [7:0] sh = 8'h00;
    logic       ssof = 1'b0, sbad = 1'b0;
    logic       epv = 1'b0, epsof = 1'b0, epbad = 1'b0;
    logic [7:0] epd = 8'h00;
    logic       eovf = 1'b0;
    logic       blat = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            acc = 0; rem = 0; sh = 8'h00; ssof = 0; sbad = 0;
            epv = 0; epsof = 0; epbad = 0; epd = 8'h00; eovf = 0; blat = 0;
        end else begin
            int   pre_size;
            bit   slot, pop, b;
            logic [9:0] e;
            pre_size = q.size();
            slot = in_tick && (acc + KEEP >= SPAN);
            pop  = slot && (pre_size > 0) && (rem <= 1);
            if (rem > 0) begin
                rem = rem - 1;
                sh  = sh << 1;
            end
            epv = 0;
            if (pop) begin
                e = q.pop_front();
                if (serial_mode) begin
                    sh = e[7:0]; rem = 8; ssof = e[8]; sbad = e[9];
                end else begin
                    epv = 1; epd = e[7:0]; epsof = e[8]; epbad = e[9];
                end
            end
            if (in_tick) acc = slot ? acc + KEEP - SPAN : acc + KEEP;
            if (in_tick && in_valid) begin
                b = in_sof ? in_bad : blat;
                if (in_sof) blat = in_bad;
                if (pre_size >= DEPTH) eovf = 1;
                else q.push_back({b, in_sof, in_data});
            end
        end
    end

    // ---------------- monitor ----------------
    int         tick_no = 0;
    int         par_cnt = 0;
    int         ser_starts = 0;
    logic [7:0] last_pd = 8'h00;
    bit         gap_on = 0;
    int         last_tick = 0;
    logic       ser_prev = 1'b0;

    always @(negedge clk) begin
        check(par_valid == epv, "R2", "par_valid", par_valid, epv);
        if (epv) check(par_data == epd, "R2", "par_data", par_data, epd);
        check(ser_valid == (rem > 0), "R3", "ser_valid", ser_valid, rem > 0);
        if (rem > 0) check(ser_bit == sh[7], "R3", "ser_bit", ser_bit, sh[7]);
        check(frm_sof == ((epv && epsof) || (rem == 8 && ssof)), "R5", "frm_sof",
              frm_sof, (epv && epsof) || (rem == 8 && ssof));
        check(frm_bad == ((epv && epbad) || (rem > 0 && sbad)), "R6", "frm_bad",
              frm_bad, (epv && epbad) || (rem > 0 && sbad));
        check(overflow == eovf, "R7", "overflow", overflow, eovf);
        if (par_valid) begin
            par_cnt++;
            last_pd = par_data;
            if (gap_on) check(tick_no - last_tick <= 2, "R1", "tick spacing",
                              tick_no - last_tick, 2);
            last_tick = tick_no;
        end
        if (ser_valid && !ser_prev) ser_starts++;
        ser_prev = ser_valid;
    end

    // ---------------- stimulus ----------------
    task automatic one_tick(input bit v, input logic [7:0] d, input bit s, input bit b);
        @(negedge clk);
        in_tick = 1; in_valid = v; in_data = d; in_sof = s; in_bad = b;
        tick_no++;
        @(negedge clk);
        in_tick = 0; in_valid = 0; in_sof = 0; in_bad = 0;
        repeat (GAP - 2) @(negedge clk);
    endtask

    task automatic send_frame(input int seed, input bit bad, input int switch_at);
        for (int i = 0; i < KEEP; i++) begin
            if (i == switch_at) serial_mode = ~serial_mode;
            one_tick(1, 8'((seed * 37 + i * 13) & 8'hFF), i == 0, bad);
        end
        for (int i = 0; i < SPAN - KEEP; i++)
            one_tick(0, 8'((seed + i) * 91), 1, 1);   // idle, garbage lines
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (4) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int snap, p0, s0;
        repeat (4) @(negedge clk);
        rst = 0;
        // R9: reset state
        check(!par_valid && !ser_valid && !frm_sof && !frm_bad && !overflow, "R9",
              "outputs after reset", {par_valid, ser_valid, frm_sof, frm_bad, overflow}, 0);

        // R8: empty slots and invalid ticks store and produce nothing
        for (int i = 0; i < 20; i++) one_tick(0, 8'h3C, 1, 1);
        check(par_cnt == 0 && ser_starts == 0, "R8", "outputs on empty slots",
              par_cnt + ser_starts, 0);
        one_tick(1, 8'hA5, 0, 0);
        for (int i = 0; i < 3; i++) one_tick(0, 8'h5A, 0, 0);
        check(par_cnt == 1, "R8", "bytes after one stored", par_cnt, 1);
        check(last_pd == 8'hA5, "R8", "only the valid byte", last_pd, 8'hA5);

        // R2 R5 R6: parallel frames, one undecodable
        send_frame(1, 0, -1);
        send_frame(2, 1, -1);
        send_frame(3, 0, -1);

        // R4: mode change inside a frame
        for (int i = 0; i < 100; i++) one_tick(1, 8'(i * 7), i == 0, 1);
        serial_mode = 1;
        p0 = par_cnt; s0 = ser_starts;
        for (int i = 0; i < 20; i++) one_tick(1, 8'(i * 11 + 3), 0, 0);
        check(par_cnt == p0, "R4", "parallel bytes after switch", par_cnt - p0, 0);
        check(ser_starts - s0 >= 15, "R4", "serial bytes after switch", ser_starts - s0, 15);
        for (int i = 0; i < 68; i++) one_tick(1, 8'(i * 5 + 1), 0, 0);
        for (int i = 0; i < 16; i++) one_tick(0, 8'hEE, 0, 1);

        // R3: serial frames, one undecodable, then switch back mid frame
        send_frame(4, 1, -1);
        send_frame(5, 0, 90);
        for (int i = 0; i < 40; i++) one_tick(0, 8'h00, 0, 0);

        // R1 R7: continuous stream, rate window and overflow
        serial_mode = 0;
        do_reset();
        snap = 0;
        for (int i = 0; i < 3600; i++) begin
            if (i == 20) begin gap_on = 1; last_tick = tick_no; end
            if (i == 300) snap = par_cnt;
            if (i == 504) check(par_cnt - snap == KEEP, "R1", "bytes in 204 ticks",
                                par_cnt - snap, KEEP);
            one_tick(1, 8'(i * 29 + 7), (i % KEEP) == 0, (i / KEEP) % 2 == 1);
        end
        gap_on = 0;
        check(overflow == 1, "R7", "overflow after long stream", overflow, 1);
        for (int i = 0; i < 5; i++) one_tick(0, 8'h00, 0, 0);
        check(overflow == 1, "R7", "overflow sticky", overflow, 1);
        do_reset();
        @(negedge clk);
        check(overflow == 0 && !par_valid, "R9", "overflow cleared by reset", overflow, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule